// File: doc/BRIEF.md
# Prime Implicant Cover Selector

This block receives a prime-implicant chart and picks a small set of implicants (rows) that covers every required minterm (column). The chart holds up to sixteen rows, each a sixteen-bit coverage vector, and a sixteen-bit mask marks which columns must be covered. Columns outside the mask are don't-cares.

A pulse on `start` latches the chart and begins an iterative search run by a state machine. The search first takes rows that are the only cover for some column. When no such row exists, it prunes rows and columns by dominance. When pruning removes nothing, the chart is cyclic, and one row is chosen by a fixed tie rule. Each selected row is removed from the chart together with the columns it covers. When no required column is left, `done` rises. The chosen rows appear as a bit mask on `sel_mask` and stay there until the next accepted start.

Top module: `pi_cover_select`

## Requirements
- R1: A `start` pulse seen while the block is idle or finished latches `row_cov` and `req_mask` and begins a search. Row r occupies bits [16r+15:16r], and bit c of that slice set means row r covers column c. A `start` seen while a search runs is ignored, and later changes on the chart inputs do not affect that search.
- R2: Only columns whose `req_mask` bit is 1 must be covered. A column with its bit at 0 is a don't-care and never causes a row to be selected.
- R3: A live required column covered by exactly one live row makes that row essential. The row's bit is set in `sel_mask`, and the row and every column it covers leave the chart.
- R4: A live required column that no live row covers is dropped and stays uncovered. The search still completes.
- R5: When no essential row exists, a live row whose coverage of the live columns is a subset of another live row's coverage is removed. For equal coverage the lower row index is kept.
- R6: In the same reduction step, a live column whose set of live rows is a superset of another live column's non-empty row set is removed. For equal row sets the lower column index is kept.
- R7: When reduction removes nothing, the chart is cyclic. The block selects the live row covering the most live columns, taking the lowest index on a tie, removes it and its columns, and repeats the essential search.
- R8: `done` is 1 exactly when a search has left no required column. `done` and `sel_mask` hold until the next accepted `start`, which clears `done` on the following cycle. An all-zero `req_mask` finishes with an empty selection.
- R9: While reset is active, `done` and `sel_mask` are 0.
- R10: For the chart of minterms 2,4,6,8,9,10,12,13,15 with implicants 0-10, -010, 01-0, -100, 10-0, 1-00, 1-0-, 11-1 on rows 0 to 7, the selection is rows 1, 2, 6 and 7 (mask 0x00C6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begins a search with the present chart inputs |
| row_cov | input | 256 | Coverage vectors, 16 bits per row, row 0 in the low bits |
| req_mask | input | 16 | Columns that must be covered |
| sel_mask | output | 16 | Selected rows, bit r for row r |
| done | output | 1 | Search finished, selection valid |

## Verification
The bench targets several corner cases, each with a known wrong result:
- Cyclic charts in two row orders: a wrong tie rule or a missing reduction gives a four-row selection or the wrong rows.
- Duplicate rows with identical columns: if the tie rule is broken, both rows are removed or both are kept.
- A don't-care column that only an extra row covers: a design that treats it as required selects that row.
- An uncoverable column: a design that does not drop it hangs and never raises `done`.
- Two checks target the latch: changing the chart and pulsing `start` mid-search, then changing the inputs after `done`. A design that does not latch, or does not hold its result, shows a different mask.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ESS  = 3'd1,
    ST_RED  = 3'd2,
    ST_CYC  = 3'd3,
    ST_DONE = 3'd4
  } pic_state_e;
endpackage

// File: rtl/pic_ess_find.sv
// Per-column search for sole covering rows and for columns nobody covers.
module pic_ess_find #(
  parameter int NR = 16,
  parameter int NC = 16
) (
  input  logic [NR*NC-1:0] cov,
  input  logic [NR-1:0]    row_live,
  input  logic [NC-1:0]    col_live,
  output logic [NR-1:0]    ess_rows,
  output logic [NC-1:0]    dead_cols
);
  localparam logic [NR-1:0] ONE_R = {{(NR-1){1'b0}}, 1'b1};

  logic [NR-1:0] contrib [NC];

  for (genvar c = 0; c < NC; c++) begin : g_col
    logic [NR-1:0] rs;
    logic          single;
    always_comb begin
      for (int r = 0; r < NR; r++) rs[r] = cov[r*NC + c] & row_live[r];
    end
    assign single       = (rs != '0) && ((rs & (rs - ONE_R)) == '0);
    assign contrib[c]   = (col_live[c] && single) ? rs : '0;
    assign dead_cols[c] = col_live[c] && (rs == '0);
  end

  always_comb begin
    ess_rows = '0;
    for (int c = 0; c < NC; c++) ess_rows = ess_rows | contrib[c];
  end
endmodule

// File: rtl/pic_row_dom.sv
// Marks live rows whose live coverage is contained in another live row.
module pic_row_dom #(
  parameter int NR = 16,
  parameter int NC = 16
) (
  input  logic [NR*NC-1:0] cov,
  input  logic [NR-1:0]    row_live,
  input  logic [NC-1:0]    col_live,
  output logic [NR-1:0]    row_drop
);
  for (genvar i = 0; i < NR; i++) begin : g_row
    logic [NC-1:0] ci;
    logic [NC-1:0] cj;
    logic          hit;
    assign ci = cov[i*NC +: NC] & col_live;
    always_comb begin
      hit = 1'b0;
      cj  = '0;
      for (int j = 0; j < NR; j++) begin
        cj = cov[j*NC +: NC] & col_live;
        if (j != i && row_live[j] && ((ci & ~cj) == '0) && ((ci != cj) || (j < i)))
          hit = 1'b1;
      end
    end
    assign row_drop[i] = row_live[i] & hit;
  end
endmodule

// File: rtl/pic_col_dom.sv
// Marks live columns whose live row set contains another column's row set.
module pic_col_dom #(
  parameter int NR = 16,
  parameter int NC = 16
) (
  input  logic [NR*NC-1:0] cov,
  input  logic [NR-1:0]    row_live,
  input  logic [NC-1:0]    col_live,
  output logic [NC-1:0]    col_drop
);
  logic [NR-1:0] crows [NC];

  always_comb begin
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++)
        crows[c][r] = cov[r*NC + c] & row_live[r];
  end

  for (genvar c = 0; c < NC; c++) begin : g_col
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int d = 0; d < NC; d++) begin
        if (d != c && col_live[d] && (crows[d] != '0) &&
            ((crows[d] & ~crows[c]) == '0) && ((crows[d] != crows[c]) || (d < c)))
          hit = 1'b1;
      end
    end
    assign col_drop[c] = col_live[c] & hit;
  end
endmodule

// File: rtl/pic_cyc_pick.sv
// Cyclic-chart choice: widest live row, lowest index on a tie.
module pic_cyc_pick #(
  parameter int NR = 16,
  parameter int NC = 16
) (
  input  logic [NR*NC-1:0] cov,
  input  logic [NR-1:0]    row_live,
  input  logic [NC-1:0]    col_live,
  output logic [NR-1:0]    pick
);
  always_comb begin
    int best;
    int cnt;
    best = 0;
    pick = '0;
    for (int r = 0; r < NR; r++) begin
      cnt = row_live[r] ? $countones(cov[r*NC +: NC] & col_live) : 0;
      if (cnt > best) begin
        best    = cnt;
        pick    = '0;
        pick[r] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pi_cover_select.sv
module pi_cover_select
  import pic_pkg::*;
#(
  parameter int NR = 16,
  parameter int NC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NR*NC-1:0] row_cov,
  input  logic [NC-1:0]    req_mask,
  output logic [NR-1:0]    sel_mask,
  output logic             done
);
  localparam int CW = NR * NC;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  pic_state_e    st, st_n;
  logic [CW-1:0] cov_q, cov_n;
  logic [NR-1:0] row_live, rl_n, sel_q, sel_n;
  logic [NC-1:0] col_live, cl_n;
  logic          busy, upd;

  logic [NR-1:0] ess_rows, row_drop, pick;
  logic [NC-1:0] dead_cols, col_drop, ess_cover, pick_cover;

  pic_ess_find #(.NR(NR), .NC(NC)) u_ess (
    .cov(cov_q), .row_live(row_live), .col_live(col_live),
    .ess_rows(ess_rows), .dead_cols(dead_cols));

  pic_row_dom #(.NR(NR), .NC(NC)) u_rdom (
    .cov(cov_q), .row_live(row_live), .col_live(col_live), .row_drop(row_drop));

  pic_col_dom #(.NR(NR), .NC(NC)) u_cdom (
    .cov(cov_q), .row_live(row_live), .col_live(col_live), .col_drop(col_drop));

  pic_cyc_pick #(.NR(NR), .NC(NC)) u_pick (
    .cov(cov_q), .row_live(row_live), .col_live(col_live), .pick(pick));

  // columns swept out by the rows chosen this cycle
  always_comb begin
    ess_cover  = '0;
    pick_cover = '0;
    for (int r = 0; r < NR; r++) begin
      if (ess_rows[r]) ess_cover  = ess_cover  | cov_q[r*NC +: NC];
      if (pick[r])     pick_cover = pick_cover | cov_q[r*NC +: NC];
    end
  end

  assign busy = (st == ST_ESS) || (st == ST_RED) || (st == ST_CYC);
  assign upd  = busy || start;

  always_comb begin
    st_n  = st;
    cov_n = cov_q;
    rl_n  = row_live;
    cl_n  = col_live;
    sel_n = sel_q;
    case (st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          cov_n = row_cov;
          rl_n  = '1;
          cl_n  = req_mask;
          sel_n = '0;
          st_n  = ST_ESS;
        end
      end
      ST_ESS: begin
        if (col_live == '0) begin
          st_n = ST_DONE;
        end else if ((ess_rows != '0) || (dead_cols != '0)) begin
          sel_n = sel_q | ess_rows;
          rl_n  = row_live & ~ess_rows;
          cl_n  = col_live & ~dead_cols & ~ess_cover;
        end else begin
          st_n = ST_RED;
        end
      end
      ST_RED: begin
        if ((row_drop != '0) || (col_drop != '0)) begin
          rl_n = row_live & ~row_drop;
          cl_n = col_live & ~col_drop;
          st_n = ST_ESS;
        end else begin
          st_n = ST_CYC;
        end
      end
      ST_CYC: begin
        sel_n = sel_q | pick;
        rl_n  = row_live & ~pick;
        cl_n  = col_live & ~pick_cover;
        st_n  = ST_ESS;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st       <= ST_IDLE;
      row_live <= '0;
      col_live <= '0;
      sel_q    <= '0;
    end else if (upd) begin
      st       <= st_n;
      row_live <= rl_n;
      col_live <= cl_n;
      sel_q    <= sel_n;
    end
  end

  // chart storage, datapath only
  always_ff @(posedge clk) begin
    if (upd) cov_q <= cov_n;
  end

  assign sel_mask = sel_q;
  assign done     = (st == ST_DONE);

  // R3: a chosen row is never still in the chart
  p_sel_gone_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (sel_q & row_live) == '0);

  // R3: essential rows found in a cycle appear in the selection next cycle
  p_ess_taken_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_ESS && col_live != '0 && ess_rows != '0) |=>
      ((sel_q & $past(ess_rows)) == $past(ess_rows)));

  // R5: row reduction always leaves a live row
  p_row_keep_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_RED && col_live != '0) |-> ((row_live & ~row_drop) != '0));

  // R6: column reduction always leaves a live column
  p_col_keep_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_RED && col_live != '0) |-> ((col_live & ~col_drop) != '0));

  // R7: the cyclic step has exactly one candidate
  p_pick_one_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_CYC) |-> $onehot(pick));

  // R8: finished only with nothing left to cover
  p_done_empty_r8: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> (col_live == '0));

  // R8: result held while no start arrives
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (done && !start) |=> (done && $stable(sel_mask)));
endmodule

// File: tb/pi_cover_select_tb.sv
`timescale 1ns/1ps
module pi_cover_select_tb;
  localparam int NR = 16;
  localparam int NC = 16;
  localparam int NV = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [NR*NC-1:0] row_cov;
  logic [NC-1:0]    req_mask;
  logic [NR-1:0]    sel_mask;
  logic             done;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pi_cover_select #(.NR(NR), .NC(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .row_cov(row_cov),
    .req_mask(req_mask), .sel_mask(sel_mask), .done(done));

  // rows listed from row 15 down to row 0
  localparam logic [NR*NC-1:0] V_COV [NV] = '{
    {{8{16'h0000}}, 16'hA000, 16'h3300, 16'h1100, 16'h0500,
                    16'h1010, 16'h0050, 16'h0404, 16'h0044},
    {{10{16'h0000}}, 16'h00C0, 16'h00A0, 16'h0044, 16'h0022, 16'h0005, 16'h0003},
    {{10{16'h0000}}, 16'h0003, 16'h0005, 16'h0022, 16'h0044, 16'h00A0, 16'h00C0},
    {{14{16'h0000}}, 16'h000F, 16'h000F},
    {{14{16'h0000}}, 16'h0001, 16'h0002},
    {{15{16'h0000}}, 16'h0001},
    {16'hFFFF, {14{16'h0000}}, 16'h0001},
    {{14{16'h0000}}, 16'h0002, 16'h0001}
  };
  localparam logic [NC-1:0] V_REQ [NV] = '{
    16'hB754, 16'h00E7, 16'h00E7, 16'h000F, 16'h0001, 16'h0003, 16'hFFFF, 16'h0003};
  localparam logic [NR-1:0] V_SEL [NV] = '{
    16'h00C6, 16'h0019, 16'h0019, 16'h0001, 16'h0002, 16'h0001, 16'h8000, 16'h0003};
  string v_tag [NV] = '{
    "R10 R3 R5 textbook chart", "R7 R5 cyclic chart", "R7 cyclic chart reversed",
    "R5 R6 duplicate rows", "R2 dont-care column", "R4 uncoverable column",
    "R3 essential on row 15", "R3 two essentials"};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [NR*NC-1:0] cov, input logic [NC-1:0] req);
    @(negedge clk);
    row_cov  = cov;
    req_mask = req;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    rst_n = 1'b0; start = 1'b0; row_cov = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    chk(!done && sel_mask == '0, "R9 outputs in reset", {15'd0, done, sel_mask}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && sel_mask == '0, "R9 outputs after release", {15'd0, done, sel_mask}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      launch(V_COV[v], V_REQ[v]);
      wait_done(ok);
      chk(ok, {"R8 done reached: ", v_tag[v]}, 32'(ok), 32'd1);
      chk(sel_mask == V_SEL[v], v_tag[v], 32'(sel_mask), 32'(V_SEL[v]));
    end

    // R8: empty requirement finishes with nothing selected
    launch(V_COV[0], 16'h0000);
    wait_done(ok);
    chk(ok && sel_mask == '0, "R8 empty req mask", 32'(sel_mask), 32'd0);

    // R8: result held while inputs move without start
    launch(V_COV[0], V_REQ[0]);
    wait_done(ok);
    row_cov  = '1;
    req_mask = '1;
    repeat (10) @(negedge clk);
    chk(done && sel_mask == 16'h00C6, "R8 result held", 32'(sel_mask), 32'h00C6);

    // R8: accepted start clears done on the next cycle
    launch(V_COV[1], V_REQ[1]);
    chk(!done, "R8 done cleared by start", 32'(done), 32'd0);
    wait_done(ok);
    chk(ok && sel_mask == 16'h0019, "R8 R7 run after restart", 32'(sel_mask), 32'h0019);

    // R1: start and new chart during a search are ignored
    @(negedge clk);
    row_cov = V_COV[0]; req_mask = V_REQ[0]; start = 1'b1;
    @(negedge clk);
    row_cov = V_COV[7]; req_mask = V_REQ[7]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    row_cov = '1;
    wait_done(ok);
    chk(ok && sel_mask == 16'h00C6, "R1 start while busy ignored", 32'(sel_mask), 32'h00C6);

    // R9: reset in mid-search clears outputs
    launch(V_COV[1], V_REQ[1]);
    rst_n = 1'b0;
    #1;
    chk(!done && sel_mask == '0, "R9 reset mid-search", {15'd0, done, sel_mask}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule